// File: doc/BRIEF.md
# Floating-Point Status and Exception Register

This block is the status and control register of a floating-point unit. Each time the arithmetic datapath finishes an operation, it presents a completion strobe together with five raw exception indications: invalid, divide-by-zero, overflow, underflow and inexact. The register replaces its per-operation cause field with exactly that operation's exceptions. It ORs them into a sticky flag field, and it compares them with a software-controlled enable field. When a raised exception is enabled, a one-cycle exception request leaves the block, carrying the fixed floating-point exception code 0x120.

Software writes the whole register through a load port. Bits that are not implemented are masked away on write and always read as zero. Two controls are decoded from the register for the arithmetic datapath: a rounding select (truncation versus round-to-nearest-even) and a flush-to-zero control for denormal values. An operation whose result is only an approximation sets a marker. If such an operation reports no exception at all, the block records inexact in its place.

Top module: `fpsr_unit`

## Requirements
- R1: The five exception kinds share one bit order inside every field, from the field's low bit upward: inexact, underflow, overflow, divide-by-zero, invalid. The same order is used on `op_exc[4:0]`. Flags occupy bits 6:2, enables bits 11:7 and causes bits 16:12 of `fpsr_q`.
- R2: On a completion strobe without a load, the cause field (bits 16:12) holds exactly that operation's exceptions after the next clock edge. Causes from earlier operations are removed.
- R3: On a completion strobe without a load, the operation's exceptions are ORed into the flag field (bits 6:2). Flags already set stay set until software loads the register.
- R4: If a completion strobe without a load raises an exception whose enable bit (bits 11:7) is set, `exc_req` is high for exactly the following cycle, with `exc_code` = 0x120. At all other times `exc_req` is low and `exc_code` is zero.
- R5: A load stores `ld_data & 32'h0005FFFF`. Bit 17 and bits 31:19 always read as zero.
- R6: `rnd_trunc` is 1 when register bits 1:0 equal 01 (round toward zero). It is 0 for the encodings 00, 10 and 11 (round to nearest even).
- R7: `ftz` equals register bit 18.
- R8: After reset the register reads 0x00040001: rounding bits 01, bit 18 set, causes, flags and enables all zero, `exc_req` low.
- R9: When `op_approx` is high and `op_exc` is zero, the operation is treated as raising inexact alone. When `op_approx` is high and `op_exc` is nonzero, `op_exc` is used unchanged.
- R10: A load in the same cycle as a completion strobe wins. The register takes the loaded value, the strobe's exceptions are discarded, and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Software load strobe |
| ld_data | input | 32 | Value to load |
| op_done | input | 1 | Operation completion strobe |
| op_exc | input | 5 | Raw exceptions of the completing operation |
| op_approx | input | 1 | Completing operation yields an approximate result |
| fpsr_q | output | 32 | Register value |
| rnd_trunc | output | 1 | 1 = truncate, 0 = round to nearest even |
| ftz | output | 1 | Flush denormals to zero |
| exc_req | output | 1 | Floating-point exception request pulse |
| exc_code | output | 12 | Exception code, 0x120 while requesting, else 0 |

## Verification
A wrong cause or flag bit is visible in `fpsr_q` one cycle after the strobe that produced it. A lost or extra sticky flag stays visible until the next load. An enable compared against the wrong field, or against a stale cause, shows up as a missing or spurious `exc_req` in the cycle directly after the strobe. The bench also checks the decode outputs after every step, so a wrong mask or wrong rounding decode appears within one cycle of a load.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
  localparam int NEXC      = 5;
  localparam int RM_W      = 2;
  localparam int FLAG_LSB  = 2;
  localparam int EN_LSB    = 7;
  localparam int CAUSE_LSB = 12;
  localparam int DN_BIT    = 18;
  localparam logic [RM_W-1:0] RM_TRUNC = 2'b01;
  localparam logic [11:0] FPU_EXC_CODE = 12'h120;
  // exception bit indices inside each field (R1)
  localparam int X_INEXACT  = 0;
  localparam int X_UNDER    = 1;
  localparam int X_OVER     = 2;
  localparam int X_DIVZERO  = 3;
  localparam int X_INVALID  = 4;
endpackage

// File: rtl/fpsr_cause_gen.sv
module fpsr_cause_gen
  import fpsr_pkg::*;
#(
  parameter int N = NEXC
) (
  input  logic [N-1:0] raw_exc,
  input  logic         approx,
  output logic [N-1:0] eff_exc
);
  localparam logic [N-1:0] ONLY_INEXACT = N'(1) << X_INEXACT;

  always_comb begin
    if (approx && (raw_exc == '0)) eff_exc = ONLY_INEXACT;
    else                           eff_exc = raw_exc;
  end
endmodule

// File: rtl/fpsr_reg.sv
module fpsr_reg
  import fpsr_pkg::*;
#(
  parameter int          W         = 32,
  parameter int          N         = NEXC,
  parameter logic [31:0] RESET_VAL = 32'h0004_0001,
  parameter logic [31:0] WR_MASK   = 32'h0005_FFFF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_en,
  input  logic [W-1:0] ld_data,
  input  logic         done,
  input  logic [N-1:0] eff_exc,
  output logic [W-1:0] q,
  output logic         req
);
  logic [N-1:0] hit;
  logic [N-1:0] enables;

  assign enables = q[EN_LSB +: N];

  for (genvar i = 0; i < N; i++) begin : g_hit
    assign hit[i] = eff_exc[i] & enables[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q   <= RESET_VAL[W-1:0];
      req <= 1'b0;
    end else if (ld_en) begin
      q   <= ld_data & WR_MASK[W-1:0];
      req <= 1'b0;
    end else if (done) begin
      q[CAUSE_LSB +: N] <= eff_exc;
      q[FLAG_LSB +: N]  <= q[FLAG_LSB +: N] | eff_exc;
      req <= |hit;
    end else begin
      req <= 1'b0;
    end
  end

  p_cause_overwrite_r2: assert property (@(posedge clk) disable iff (rst)
    (done && !ld_en) |=> (q[CAUSE_LSB +: N] == $past(eff_exc)));

  p_flags_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    (!ld_en) |=> ((q[FLAG_LSB +: N] & $past(q[FLAG_LSB +: N])) == $past(q[FLAG_LSB +: N])));

  p_req_source_r4: assert property (@(posedge clk) disable iff (rst)
    req |-> ($past(done) && !$past(ld_en)));

  p_load_wins_r10: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> (q == ($past(ld_data) & WR_MASK[W-1:0]) && !req));
endmodule

// File: rtl/fpsr_mode_dec.sv
module fpsr_mode_dec
  import fpsr_pkg::*;
(
  input  logic [RM_W-1:0] rm_field,
  input  logic            dn_bit,
  input  logic            req,
  output logic            rnd_trunc,
  output logic            ftz,
  output logic [11:0]     exc_code
);
  always_comb begin
    rnd_trunc = (rm_field == RM_TRUNC);
    ftz       = dn_bit;
    exc_code  = req ? FPU_EXC_CODE : 12'h000;
  end
endmodule

// File: rtl/fpsr_unit.sv
module fpsr_unit
  import fpsr_pkg::*;
#(
  parameter int          W         = 32,
  parameter logic [31:0] RESET_VAL = 32'h0004_0001,
  parameter logic [31:0] WR_MASK   = 32'h0005_FFFF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_en,
  input  logic [31:0]  ld_data,
  input  logic         op_done,
  input  logic [4:0]   op_exc,
  input  logic         op_approx,
  output logic [31:0]  fpsr_q,
  output logic         rnd_trunc,
  output logic         ftz,
  output logic         exc_req,
  output logic [11:0]  exc_code
);
  logic [NEXC-1:0] eff_exc;

  fpsr_cause_gen #(.N(NEXC)) u_cause (
    .raw_exc (op_exc),
    .approx  (op_approx),
    .eff_exc (eff_exc)
  );

  fpsr_reg #(.W(W), .N(NEXC), .RESET_VAL(RESET_VAL), .WR_MASK(WR_MASK)) u_reg (
    .clk     (clk),
    .rst     (rst),
    .ld_en   (ld_en),
    .ld_data (ld_data),
    .done    (op_done),
    .eff_exc (eff_exc),
    .q       (fpsr_q),
    .req     (exc_req)
  );

  fpsr_mode_dec u_dec (
    .rm_field  (fpsr_q[RM_W-1:0]),
    .dn_bit    (fpsr_q[DN_BIT]),
    .req       (exc_req),
    .rnd_trunc (rnd_trunc),
    .ftz       (ftz),
    .exc_code  (exc_code)
  );

  p_reset_value_r8: assert property (@(posedge clk)
    rst |=> (fpsr_q == RESET_VAL && !exc_req));

  p_unimpl_zero_r5: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> ((fpsr_q & ~WR_MASK) == 32'h0));

  p_trunc_load_r6: assert property (@(posedge clk) disable iff (rst)
    (ld_en && ld_data[1:0] == 2'b01) |=> rnd_trunc);

  p_ftz_load_r7: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> (ftz == $past(ld_data[DN_BIT])));

  p_approx_nonzero_r9: assert property (@(posedge clk) disable iff (rst)
    (op_done && op_approx && !ld_en) |=> (fpsr_q[CAUSE_LSB +: NEXC] != '0));

  p_code_r4: assert property (@(posedge clk) disable iff (rst)
    exc_req |-> (exc_code == 12'h120));
endmodule

// File: tb/fpsr_unit_bench.sv
module fpsr_unit_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        ld_en;
  logic [31:0] ld_data;
  logic        op_done;
  logic [4:0]  op_exc;
  logic        op_approx;
  logic [31:0] fpsr_q;
  logic        rnd_trunc, ftz, exc_req;
  logic [11:0] exc_code;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] model_q;
  logic [31:0] sb_q[$];
  logic        sb_req[$];
  string       sb_tag[$];
  bit          done_all = 0;

  always #4 clk = ~clk;

  fpsr_unit u_fpsr_unit (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_data(ld_data),
    .op_done(op_done), .op_exc(op_exc), .op_approx(op_approx),
    .fpsr_q(fpsr_q), .rnd_trunc(rnd_trunc), .ftz(ftz),
    .exc_req(exc_req), .exc_code(exc_code)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, expected outcome pushed into the scoreboard
  task automatic step(input string tag, input logic ld, input logic [31:0] wd,
                      input logic dn, input logic [4:0] raw, input logic apx);
    logic [4:0] eff;
    logic       r;
    @(negedge clk);
    ld_en = ld; ld_data = wd; op_done = dn; op_exc = raw; op_approx = apx;
    r = 1'b0;
    if (ld) begin
      model_q = wd & 32'h0005_FFFF;
    end else if (dn) begin
      eff = (apx && raw == 5'd0) ? 5'b00001 : raw;
      r = |(eff & model_q[11:7]);
      model_q[16:12] = eff;
      model_q[6:2]   = model_q[6:2] | eff;
    end
    sb_q.push_back(model_q);
    sb_req.push_back(r);
    sb_tag.push_back(tag);
  endtask

  // monitor: compare after each active edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        logic [31:0] eq;
        logic        er;
        string       t;
        eq = sb_q.pop_front(); er = sb_req.pop_front(); t = sb_tag.pop_front();
        check(t, "fpsr_q", fpsr_q, eq);
        check(t, "exc_req", {31'd0, exc_req}, {31'd0, er});
        check(t, "exc_code", {20'd0, exc_code}, er ? 32'h120 : 32'h0);
        check(t, "rnd_trunc", {31'd0, rnd_trunc}, {31'd0, eq[1:0] == 2'b01});
        check(t, "ftz", {31'd0, ftz}, {31'd0, eq[18]});
      end
    end
  end

  initial begin
    rst = 1'b1; ld_en = 0; ld_data = '0; op_done = 0; op_exc = '0; op_approx = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R8 reset state
    check("R8", "reset fpsr_q", fpsr_q, 32'h0004_0001);
    check("R8", "reset rnd_trunc", {31'd0, rnd_trunc}, 32'd1);
    check("R8", "reset ftz", {31'd0, ftz}, 32'd1);
    check("R8", "reset exc_req", {31'd0, exc_req}, 32'd0);
    model_q = 32'h0004_0001;

    step("R5", 1, 32'hFFFF_FFFF, 0, 5'd0, 0);       // mask, rm=11
    step("R6", 1, 32'h0000_0002, 0, 5'd0, 0);       // rm=10, ftz off (R7)
    step("R6", 1, 32'h0004_0000, 0, 5'd0, 0);       // rm=00, ftz on
    step("R6", 1, 32'h0000_0001, 0, 5'd0, 0);       // rm=01 truncation
    step("R2", 0, 32'h0, 1, 5'b10000, 0);           // invalid, no enable
    step("R3", 0, 32'h0, 1, 5'b00100, 0);           // overflow, flags keep invalid
    step("R2", 0, 32'h0, 1, 5'b00000, 0);           // cause cleared, flags kept
    step("R3", 0, 32'h0, 0, 5'b11111, 0);           // no strobe: ignored
    step("R1", 1, 32'h0000_0401, 0, 5'd0, 0);       // enable divide-by-zero (bit 10)
    step("R4", 0, 32'h0, 1, 5'b01000, 0);           // request
    step("R4", 0, 32'h0, 0, 5'd0, 0);               // pulse over
    step("R4", 0, 32'h0, 1, 5'b00010, 0);           // underflow not enabled
    step("R9", 0, 32'h0, 1, 5'b00000, 1);           // approx -> inexact only
    step("R9", 0, 32'h0, 1, 5'b00010, 1);           // approx with underflow
    step("R10", 1, 32'h0000_0081, 1, 5'b01000, 0);  // load wins, enables inexact
    step("R10", 0, 32'h0, 0, 5'd0, 0);
    step("R9", 0, 32'h0, 1, 5'b00000, 1);           // approx inexact requests
    step("R4", 0, 32'h0, 1, 5'b01000, 0);           // back-to-back, divzero not enabled now
    step("R5", 1, 32'h0002_0000, 0, 5'd0, 0);       // bit 17 unimplemented
    step("R8", 0, 32'h0, 0, 5'd0, 0);
    repeat (3) @(negedge clk);
    done_all = 1;
  end

  initial begin
    fork
      begin wait (done_all); end
      begin
        repeat (5000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule